// File: doc/BRIEF.md
# Lockstep Torus SIMD Processing Array

A rectangular grid of small integer processing elements that all execute the same instruction in the same cycle. A host hands the array one 32-bit integer instruction per valid/ready beat. Every element holds sixteen 32-bit registers, a compare flag, an integer ALU, a fixed identifier and a stack of saved enable bits. Register 0 is an ordinary register. The array has no divide operation.

Elements move register values to their north, south, east or west neighbour over dedicated point-to-point links. The links wrap at the grid edges, so the grid forms a torus. All elements issue the same directional transfer in the same cycle, so the links need no routing, arbitration or buffering. A compare followed by a push of the enable stack switches off the elements whose compare failed. A pop brings back the enable state that was saved before. The host sees the OR of all compare flags as one status bit. It can also read any register of any element through a combinational peek port.

Top module: `torus_simd_array`

## Requirements
- R1: While reset is asserted and right after it, every register of every element reads 0, status_any and mask_fault are 0, instr_ready is 0 during reset, and every element is enabled.
- R2: Instruction fields are placed as follows: opcode in bits [31:27], destination register in [26:23], first source in [22:19], second source in [18:15], transfer direction in [14:13] (0 north, 1 east, 2 south, 3 west), and a 16-bit immediate in [15:0].
- R3: Opcodes 1 to 9 write the destination with, in order: AND, OR, XOR, NOT of the first source, shift left, logical shift right, add, subtract, and the low 32 bits of the product. Shifts use only the low 5 bits of the second source. Add and subtract wrap.
- R4: Opcode 10 (compare) sets the element flag to (first source == second source). Opcode 11 (conditional move) copies the first source into the destination only where the flag is 1.
- R5: Opcode 13 writes the zero-extended immediate. Opcode 14 writes the element identifier, where the identifier is y*NX+x (row-major, starting at 0).
- R6: Opcode 12 (transfer) writes each sender's first source into the destination register of its neighbour in the named direction. North means row y-1, east means column x+1, and both wrap. Every element samples its neighbour's value before any register is written, so opposite elements swap.
- R7: On a 2x2 array holding 1 to 4, NX-1 rounds of (transfer east, add), then a copy of the row sum, then NY-1 rounds of (transfer north, add) leave 10 in every element.
- R8: Opcode 15 (push) saves the current enable bit and ANDs it with the flag. A disabled element changes no register and no flag. A transfer writes only where both the sender and the receiver are enabled.
- R9: Opcode 16 (pop) restores the enable bit saved by the matching push.
- R10: The stack holds MSTK entries (default 4). A push onto a full stack or a pop from an empty stack sets mask_fault, leaves the enable bits unchanged, and mask_fault stays set until reset.
- R11: status_any is the OR of the compare flags of all elements.
- R12: An instruction executes only on a cycle with instr_valid and instr_ready both high. Opcode 0 and opcodes 17 to 31 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Host offers an instruction |
| instr_ready | output | 1 | Array accepts an instruction (high when not in reset) |
| instr_word | input | 32 | Integer-slot instruction |
| status_any | output | 1 | OR of all element compare flags |
| mask_fault | output | 1 | Sticky enable-stack overflow/underflow |
| peek_pe | input | 2 | Element selected for readout |
| peek_reg | input | 4 | Register selected for readout |
| peek_data | output | 32 | Value of the selected register |

## Verification
The assertions check on every cycle the rules that hold at any single step. A disabled element and a cycle with no accepted instruction both leave the register file and the flag unchanged. A pop restores the saved enable bit. The stack pointer never passes its depth, and the fault bit never clears. Only the bench scenarios can show the values that come out of the instructions. These include the ALU results and shift masking, the torus wrap and simultaneous swaps, the two-phase sum reaching 10 everywhere, and fault handling that leaves the enable bits untouched.

// File: rtl/torus_simd_pkg.sv
package torus_simd_pkg;
  localparam int DATA_W = 32;
  localparam int NREG   = 16;
  localparam int RA_W   = $clog2(NREG);
  localparam int SH_W   = $clog2(DATA_W);
  localparam int OP_W   = 5;

  typedef enum logic [OP_W-1:0] {
    OP_NOP = 5'd0,  OP_AND = 5'd1,  OP_OR   = 5'd2,  OP_XOR  = 5'd3,
    OP_NOT = 5'd4,  OP_SHL = 5'd5,  OP_SHR  = 5'd6,  OP_ADD  = 5'd7,
    OP_SUB = 5'd8,  OP_MUL = 5'd9,  OP_CMP  = 5'd10, OP_CMOV = 5'd11,
    OP_XFER = 5'd12, OP_LDI = 5'd13, OP_PEID = 5'd14, OP_PUSHM = 5'd15,
    OP_POPM = 5'd16
  } op_e;

  localparam logic [OP_W-1:0] OP_LAST = 5'd16;

  typedef struct packed {
    op_e             op;
    logic [RA_W-1:0] rd;
    logic [RA_W-1:0] ra;
    logic [RA_W-1:0] rb;
    logic [1:0]      dir;   // 0 N, 1 E, 2 S, 3 W
    logic [15:0]     imm;
  } uop_t;

  // Two-operand integer result for opcodes 1..9
  function automatic logic [DATA_W-1:0] alu_calc(op_e op, logic [DATA_W-1:0] a,
                                                 logic [DATA_W-1:0] b);
    logic [DATA_W-1:0] r;
    case (op)
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      OP_NOT:  r = ~a;
      OP_SHL:  r = a << b[SH_W-1:0];
      OP_SHR:  r = a >> b[SH_W-1:0];
      OP_ADD:  r = a + b;
      OP_SUB:  r = a - b;
      OP_MUL:  r = a * b;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic is_alu(op_e op);
    return (op >= OP_AND) && (op <= OP_MUL);
  endfunction
endpackage

// File: rtl/simd_decoder.sv
module simd_decoder
  import torus_simd_pkg::*;
(
  input  logic [31:0] instr_word,
  output uop_t        uop
);
  logic [OP_W-1:0] raw_op;
  assign raw_op = instr_word[31:27];

  always_comb begin
    uop.op  = (raw_op > OP_LAST) ? OP_NOP : op_e'(raw_op);
    uop.rd  = instr_word[26:23];
    uop.ra  = instr_word[22:19];
    uop.rb  = instr_word[18:15];
    uop.dir = instr_word[14:13];
    uop.imm = instr_word[15:0];
  end
endmodule

// File: rtl/simd_pe.sv
module simd_pe
  import torus_simd_pkg::*;
#(
  parameter int PE_ID = 0,
  parameter int MSTK  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   exec,
  input  uop_t                   uop,
  input  logic [3:0][DATA_W-1:0] xin_data,
  input  logic [3:0]             xin_act,
  output logic [DATA_W-1:0]      xout_data,
  output logic                   xout_act,
  output logic                   flag_o,
  output logic                   fault_o,
  input  logic [RA_W-1:0]        dbg_reg,
  output logic [DATA_W-1:0]      dbg_data
);
  localparam int PW = $clog2(MSTK + 1);
  localparam int IW = (MSTK > 1) ? $clog2(MSTK) : 1;

  logic [NREG-1:0][DATA_W-1:0] rf;
  logic                        flag_q, mask_q, fault_q;
  logic [MSTK-1:0]             stk;
  logic [PW-1:0]               ptr_q, ptr_dec;
  logic [DATA_W-1:0]           opa, opb, wr_val;
  logic                        wr_en, wr_go;
  logic                        push_ev, pop_ev, stk_full, stk_empty;
  logic                        pop_val;

  assign opa       = rf[uop.ra];
  assign opb       = rf[uop.rb];
  assign xout_data = opa;
  assign xout_act  = mask_q;
  assign flag_o    = flag_q;
  assign fault_o   = fault_q;
  assign dbg_data  = rf[dbg_reg];

  // named events for assertions
  assign push_ev   = exec && (uop.op == OP_PUSHM);
  assign pop_ev    = exec && (uop.op == OP_POPM);
  assign stk_full  = (ptr_q == PW'(MSTK));
  assign stk_empty = (ptr_q == '0);
  assign ptr_dec   = ptr_q - PW'(1);
  assign pop_val   = stk[ptr_dec[IW-1:0]];

  always_comb begin
    wr_en  = 1'b0;
    wr_val = alu_calc(uop.op, opa, opb);
    if (is_alu(uop.op)) wr_en = 1'b1;
    case (uop.op)
      OP_CMOV: begin wr_en = flag_q; wr_val = opa; end
      OP_XFER: begin wr_en = xin_act[uop.dir]; wr_val = xin_data[uop.dir]; end
      OP_LDI:  begin wr_en = 1'b1; wr_val = {{(DATA_W-16){1'b0}}, uop.imm}; end
      OP_PEID: begin wr_en = 1'b1; wr_val = DATA_W'(PE_ID); end
      default: ;
    endcase
  end
  assign wr_go = exec && mask_q && wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_go) rf[uop.rd] <= wr_val;
      if (exec && mask_q && uop.op == OP_CMP) flag_q <= (opa == opb);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= 1'b1;
      stk     <= '0;
      ptr_q   <= '0;
      fault_q <= 1'b0;
    end else if (push_ev) begin
      if (stk_full) fault_q <= 1'b1;
      else begin
        stk[ptr_q[IW-1:0]] <= mask_q;
        ptr_q  <= ptr_q + PW'(1);
        mask_q <= mask_q & flag_q;
      end
    end else if (pop_ev) begin
      if (stk_empty) fault_q <= 1'b1;
      else begin
        ptr_q  <= ptr_dec;
        mask_q <= pop_val;
      end
    end
  end

  assert_masked_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !mask_q) |=> ($stable(rf) && $stable(flag_q)));
  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> $stable(rf));
  assert_pop_restore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ev && !stk_empty) |=> (mask_q == $past(pop_val)));
  assert_ptr_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= PW'(MSTK));
endmodule

// File: rtl/torus_simd_array.sv
module torus_simd_array
  import torus_simd_pkg::*;
#(
  parameter int NX   = 2,
  parameter int NY   = 2,
  parameter int MSTK = 4,
  localparam int NPE = NX * NY,
  localparam int PEW = (NPE > 1) ? $clog2(NPE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  output logic              instr_ready,
  input  logic [31:0]       instr_word,
  output logic              status_any,
  output logic              mask_fault,
  input  logic [PEW-1:0]    peek_pe,
  input  logic [RA_W-1:0]   peek_reg,
  output logic [DATA_W-1:0] peek_data
);
  logic                            ready_q, fire;
  uop_t                            uop;
  logic [NPE-1:0][DATA_W-1:0]      src_d, dbg_d;
  logic [NPE-1:0]                  src_a, flags, faults;
  logic [NPE-1:0][3:0][DATA_W-1:0] xin_d;
  logic [NPE-1:0][3:0]             xin_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign instr_ready = ready_q;
  assign fire        = instr_valid && ready_q;

  simd_decoder u_dec (.instr_word(instr_word), .uop(uop));

  for (genvar i = 0; i < NPE; i++) begin : g_pe
    localparam int X  = i % NX;
    localparam int Y  = i / NX;
    localparam int FN = X + ((Y + 1) % NY) * NX;       // sender for a north move
    localparam int FE = ((X + NX - 1) % NX) + Y * NX;  // sender for an east move
    localparam int FS = X + ((Y + NY - 1) % NY) * NX;  // sender for a south move
    localparam int FW = ((X + 1) % NX) + Y * NX;       // sender for a west move

    assign xin_d[i][0] = src_d[FN];
    assign xin_d[i][1] = src_d[FE];
    assign xin_d[i][2] = src_d[FS];
    assign xin_d[i][3] = src_d[FW];
    assign xin_a[i][0] = src_a[FN];
    assign xin_a[i][1] = src_a[FE];
    assign xin_a[i][2] = src_a[FS];
    assign xin_a[i][3] = src_a[FW];

    simd_pe #(.PE_ID(i), .MSTK(MSTK)) u_pe (
      .clk(clk), .rst_n(rst_n), .exec(fire), .uop(uop),
      .xin_data(xin_d[i]), .xin_act(xin_a[i]),
      .xout_data(src_d[i]), .xout_act(src_a[i]),
      .flag_o(flags[i]), .fault_o(faults[i]),
      .dbg_reg(peek_reg), .dbg_data(dbg_d[i])
    );
  end

  assign status_any = |flags;
  assign mask_fault = |faults;

  always_comb begin
    peek_data = '0;
    for (int k = 0; k < NPE; k++)
      if (peek_pe == PEW'(k)) peek_data = dbg_d[k];
  end

  assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mask_fault |=> mask_fault);
endmodule

// File: tb/tb_torus_simd_array.sv
`timescale 1ns/1ps
module tb_torus_simd_array;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [31:0] instr_word = '0;
  logic        status_any, mask_fault;
  logic [1:0]  peek_pe = '0;
  logic [3:0]  peek_reg = '0;
  logic [31:0] peek_data;

  int tests = 0, fails = 0;
  bit done = 0, mon_busy = 0;

  int          q_kind[$];
  int          q_pe[$];
  int          q_reg[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;

  torus_simd_array dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_word(instr_word), .status_any(status_any), .mask_fault(mask_fault),
    .peek_pe(peek_pe), .peek_reg(peek_reg), .peek_data(peek_data)
  );

  // encoders, field layout from R2
  function automatic logic [31:0] e3(int op, int rd, int ra, int rb);
    return {op[4:0], rd[3:0], ra[3:0], rb[3:0], 15'd0};
  endfunction
  function automatic logic [31:0] eimm(int rd, logic [15:0] v);
    return {5'd13, rd[3:0], 7'd0, v};
  endfunction
  function automatic logic [31:0] exfer(int dir, int rd, int ra);
    return {5'd12, rd[3:0], ra[3:0], 4'd0, dir[1:0], 13'd0};
  endfunction

  // kind: 0 register, 1 status_any, 2 mask_fault, 3 instr_ready
  task automatic expect_item(int kind, int pe, int rg, logic [31:0] v, string tag);
    q_kind.push_back(kind); q_pe.push_back(pe); q_reg.push_back(rg);
    q_exp.push_back(v); q_tag.push_back(tag);
  endtask
  task automatic exp_reg(int pe, int rg, logic [31:0] v, string tag);
    expect_item(0, pe, rg, v, tag);
  endtask
  task automatic settle();
    @(posedge clk);
    while (q_kind.size() > 0 || mon_busy) @(posedge clk);
  endtask
  task automatic issue(logic [31:0] w, bit v = 1'b1);
    @(negedge clk);
    instr_word = w; instr_valid = v;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask
  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(negedge clk);
      #0.5;
      while (q_kind.size() > 0) begin
        int k, p, r; logic [31:0] e, got; string t;
        mon_busy = 1;
        k = q_kind.pop_front(); p = q_pe.pop_front(); r = q_reg.pop_front();
        e = q_exp.pop_front(); t = q_tag.pop_front();
        peek_pe = p[1:0]; peek_reg = r[3:0];
        #0.2;
        case (k)
          0: got = peek_data;
          1: got = {31'd0, status_any};
          2: got = {31'd0, mask_fault};
          default: got = {31'd0, instr_ready};
        endcase
        tests++;
        if (got !== e) begin
          fails++;
          $display("FAIL %s kind=%0d pe=%0d reg=%0d actual=%h expected=%h", t, k, p, r, got, e);
        end
        mon_busy = 0;
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: state during reset
    repeat (2) @(negedge clk);
    expect_item(3, 0, 0, 0, "R1 ready low in reset");
    exp_reg(2, 5, 0, "R1 reg zero in reset");
    settle();
    rst_n = 1'b1;
    @(negedge clk);
    expect_item(3, 0, 0, 1, "R12 ready after reset");
    expect_item(1, 0, 0, 0, "R1 status clear");
    expect_item(2, 0, 0, 0, "R1 fault clear");
    settle();

    // R5 / R3: id + 1 in r1
    issue(e3(14, 1, 0, 0));
    issue(eimm(2, 16'd1));
    issue(e3(7, 1, 1, 2));
    for (int p = 0; p < 4; p++) exp_reg(p, 1, p + 1, "R5 id+1");
    issue(eimm(4, 16'hBEEF));
    exp_reg(0, 4, 32'h0000BEEF, "R5 zero-extend imm");
    settle();

    // R3: ALU operations
    issue(eimm(5, 16'h00F0));
    issue(eimm(6, 16'h0FF0));
    issue(eimm(13, 16'd36));
    issue(e3(1, 7, 5, 6));  issue(e3(2, 8, 5, 6));  issue(e3(3, 9, 5, 6));
    issue(e3(4, 10, 5, 0)); issue(e3(8, 11, 5, 6)); issue(e3(9, 12, 5, 6));
    issue(e3(5, 14, 5, 13)); issue(e3(6, 15, 5, 13));
    exp_reg(1, 7, 32'h000000F0, "R3 and");
    exp_reg(1, 8, 32'h00000FF0, "R3 or");
    exp_reg(1, 9, 32'h00000F00, "R3 xor");
    exp_reg(1, 10, 32'hFFFFFF0F, "R3 not");
    exp_reg(1, 11, 32'hFFFFF100, "R3 sub wrap");
    exp_reg(1, 12, 32'h000EF100, "R3 mul");
    exp_reg(1, 14, 32'h00000F00, "R3 shl masked amount");
    exp_reg(1, 15, 32'h0000000F, "R3 shr masked amount");
    settle();

    // R6: east then north transfers with wrap and swap
    issue(exfer(1, 2, 1));
    exp_reg(0, 2, 2, "R6 east swap"); exp_reg(1, 2, 1, "R6 east wrap");
    exp_reg(2, 2, 4, "R6 east swap"); exp_reg(3, 2, 3, "R6 east wrap");
    settle();
    issue(exfer(0, 2, 1));
    exp_reg(0, 2, 3, "R6 north"); exp_reg(1, 2, 4, "R6 north");
    exp_reg(2, 2, 1, "R6 north wrap"); exp_reg(3, 2, 2, "R6 north wrap");
    settle();

    // R7: two-phase array sum
    issue(e3(7, 3, 1, 0));
    issue(exfer(1, 2, 1)); issue(e3(7, 3, 3, 2));
    issue(e3(2, 1, 3, 3));
    issue(exfer(0, 2, 1)); issue(e3(7, 3, 3, 2));
    for (int p = 0; p < 4; p++) exp_reg(p, 3, 10, "R7 total");
    settle();

    // R4 / R11: compare and status
    issue(e3(10, 0, 0, 1));
    expect_item(1, 0, 0, 0, "R11 no flag set");
    settle();
    issue(e3(14, 4, 0, 0));
    issue(e3(10, 0, 4, 0));
    expect_item(1, 0, 0, 1, "R11 one flag set");
    settle();
    issue(e3(11, 5, 3, 0));
    exp_reg(0, 5, 10, "R4 cmov taken"); exp_reg(1, 5, 32'h00F0, "R4 cmov skipped");
    settle();

    // R8: only element 0 enabled
    issue(e3(15, 0, 0, 0));
    issue(eimm(6, 16'h0077));
    exp_reg(0, 6, 32'h77, "R8 active write"); exp_reg(1, 6, 32'h0FF0, "R8 masked write");
    issue(exfer(1, 7, 1));
    exp_reg(0, 7, 32'hF0, "R8 masked sender"); exp_reg(1, 7, 32'hF0, "R8 masked receiver");
    settle();
    issue(e3(10, 0, 0, 0));   // would set pe1 flag if unmasked
    issue(e3(16, 0, 0, 0));
    issue(e3(11, 8, 3, 0));
    exp_reg(0, 8, 10, "R8 active flag"); exp_reg(1, 8, 32'h0FF0, "R8 masked flag kept");
    issue(eimm(9, 16'h0055));
    exp_reg(3, 9, 32'h55, "R9 pop re-enables");
    settle();

    // R10: overflow leaves enables unchanged
    issue(e3(10, 0, 0, 0));
    for (int k = 0; k < 4; k++) issue(e3(15, 0, 0, 0));
    expect_item(2, 0, 0, 0, "R10 no fault at depth");
    settle();
    issue(e3(10, 0, 4, 0));
    issue(e3(15, 0, 0, 0));
    expect_item(2, 0, 0, 1, "R10 overflow fault");
    issue(eimm(11, 16'h0099));
    exp_reg(3, 11, 32'h99, "R10 mask unchanged on overflow");
    settle();
    for (int k = 0; k < 4; k++) issue(e3(16, 0, 0, 0));
    expect_item(2, 0, 0, 1, "R10 fault sticky");
    settle();

    // R10 underflow after a fresh reset
    do_reset();
    exp_reg(0, 3, 0, "R1 regs cleared");
    expect_item(2, 0, 0, 0, "R1 fault cleared");
    settle();
    issue(e3(16, 0, 0, 0));
    expect_item(2, 0, 0, 1, "R10 underflow fault");
    issue(eimm(1, 16'd5));
    exp_reg(1, 1, 5, "R10 mask unchanged on underflow");
    settle();

    // R12: no valid, and undefined opcode
    issue(eimm(12, 16'h0123), 1'b0);
    exp_reg(0, 12, 0, "R12 no valid no effect");
    issue(e3(31, 1, 0, 0) | 32'h0000FFFF);
    exp_reg(1, 1, 5, "R12 undefined opcode no effect");
    issue(e3(0, 1, 0, 0));
    exp_reg(2, 1, 5, "R12 nop no effect");
    settle();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule